// File: doc/BRIEF.md
# Triggered Multi-Pulse Train Generator

This block turns selected bits of an angle-driven output word into timed pulse trains. It has a parameterised number of independent channels. Each channel watches one bit of the incoming trigger word for a programmed edge. On that edge it plays out a list of up to `MAX_ENTRIES` pulses. Every pulse has its own delay, counted from the end of the previous pulse (or from the trigger for the first pulse), and its own width. Both values are expressed in microsecond ticks. A tick is `TICK_DIV` system clocks, and each channel's tick counter restarts at its trigger, so the output carries no trigger-to-pulse jitter beyond one clock.

A host loads parameters through a simple write port. Delay/width pairs and the channel setup (trigger bit, edge polarity, pulse count) go into a shadow set. While a channel is idle, its active set follows the shadow set. Once a sequence starts, the active set is frozen, so a sequence already running is never disturbed by new parameters. Enable and overrun-clear are applied at once. A trigger that arrives while a channel is busy is dropped and raises a sticky per-channel overrun flag.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset, every `pulse_out` and `overrun` bit is low, every channel is disabled, and every stored delay, width and setup field is zero.
- R2: The setup word selects the trigger bit in bits [SEL_W-1:0] and the polarity in bit 8 (0 = rising edge, 1 = falling edge). Only that edge of that bit starts a sequence; the opposite edge and changes on other bits start nothing.
- R3: One tick is `TICK_DIV` clocks. A phase programmed with N ticks lasts N*TICK_DIV cycles, and a phase with N = 0 lasts one cycle. If clock edge k is the first to sample the trigger edge, `pulse_out` is high from edge k+len(delay0) for len(width0) cycles.
- R4: Entries 0 to count-1 are played in index order. Each delay is counted from the end of the previous pulse. After the last width the channel returns to idle and accepts a new trigger.
- R5: The pulse count sits in setup bits [16 +: CNT_W]. A count of 0 behaves as 1, and a count above `MAX_ENTRIES` behaves as `MAX_ENTRIES`.
- R6: An entry with zero width gives no pulse: the output stays low during its one-cycle width phase, and its delay still elapses in full.
- R7: An active trigger edge seen while a channel is running leaves the running sequence unchanged and sets that channel's `overrun`, which stays set until a control write with bit 1 set. If a set and a clear fall in the same cycle, the set wins.
- R8: Entry and setup writes land in the shadow set. A sequence uses the values present when it started. A write made in the same cycle as the starting trigger, or during the run, applies only from the next sequence.
- R9: Control bit 0 is the channel enable and takes effect one cycle after the write. Clearing it forces the output low on the following edge, abandons any sequence without raising `overrun`, and makes the channel ignore triggers.
- R10: `wr_ch` selects the channel. Address a < MAX_ENTRIES writes entry a, with the delay in the upper TIME_W bits and the width in the lower TIME_W bits. Address MAX_ENTRIES writes the setup and address MAX_ENTRIES+1 writes the control. Channels run independently, even when triggered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_word | input | WORD_W | Angle-driven word whose bits can trigger channels |
| wr_en | input | 1 | Parameter write strobe |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_addr | input | ADDR_W | Entry, setup or control address |
| wr_data | input | 2*TIME_W | Write data |
| pulse_out | output | NUM_CH | One registered pulse output per channel |
| overrun | output | NUM_CH | Sticky per-channel retrigger flag |

## Verification
Two functions can land in the same clock cycle: a host write to the shadow set, and the trigger edge that copies the shadow set into the active set. The bench drives both on the same falling clock edge. It then checks that the sequence it starts plays the old timing, and that the next trigger plays the new timing. A second collision is a retrigger arriving in the middle of a running sequence. Here the full output waveform is compared cycle by cycle with a model built from the requirements, and the sticky flag is then read before and after its clear.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GAP  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // setup word field positions
    localparam int SETUP_POL_BIT = 8;
    localparam int SETUP_CNT_LSB = 16;

    // control word bits
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;

endpackage

// File: rtl/ptg_edge_pick.sv
module ptg_edge_pick
    import ptg_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] trig_word,
    input  logic [SEL_W-1:0]  sel,
    input  logic              falling,
    output logic              fire
);

    typedef struct packed {
        logic [WORD_W-1:0] prev;
    } edge_st_t;

    edge_st_t q, d;
    logic     now_b;
    logic     was_b;

    always_comb begin
        d.prev = trig_word;
        now_b  = 1'b0;
        was_b  = 1'b0;
        if (int'(sel) < WORD_W) begin
            now_b = trig_word[sel];
            was_b = q.prev[sel];
        end
        fire = (now_b != was_b) && (now_b == !falling);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // an edge of one polarity cannot repeat on the next cycle for the same bit
    AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!fire || sel != $past(sel) || falling != $past(falling))); // R2

endmodule

// File: rtl/ptg_param_store.sv
module ptg_param_store
    import ptg_pkg::*;
#(
    parameter int MAX_ENTRIES = 10,
    parameter int TIME_W      = 16,
    parameter int SEL_W       = 4,
    parameter int CNT_W       = 4,
    parameter int ADDR_W      = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [2*TIME_W-1:0]                 wr_data,
    input  logic                                idle,
    output logic [MAX_ENTRIES-1:0][TIME_W-1:0]  v_delay,
    output logic [MAX_ENTRIES-1:0][TIME_W-1:0]  v_width,
    output logic [SEL_W-1:0]                    v_sel,
    output logic                                v_fall,
    output logic [CNT_W-1:0]                    v_cnt,
    output logic                                enable,
    output logic                                clr_ovr
);

    localparam int SETUP_ADDR = MAX_ENTRIES;
    localparam int CTRL_ADDR  = MAX_ENTRIES + 1;

    typedef struct packed {
        logic [MAX_ENTRIES-1:0][TIME_W-1:0] sh_delay;
        logic [MAX_ENTRIES-1:0][TIME_W-1:0] sh_width;
        logic [SEL_W-1:0]                   sh_sel;
        logic                               sh_fall;
        logic [CNT_W-1:0]                   sh_cnt;
        logic [MAX_ENTRIES-1:0][TIME_W-1:0] ac_delay;
        logic [MAX_ENTRIES-1:0][TIME_W-1:0] ac_width;
        logic [SEL_W-1:0]                   ac_sel;
        logic                               ac_fall;
        logic [CNT_W-1:0]                   ac_cnt;
        logic                               en;
    } store_st_t;

    store_st_t q, d;

    always_comb begin
        d       = q;
        clr_ovr = 1'b0;

        if (wr_en) begin
            for (int i = 0; i < MAX_ENTRIES; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    d.sh_delay[i] = wr_data[2*TIME_W-1:TIME_W];
                    d.sh_width[i] = wr_data[TIME_W-1:0];
                end
            end
            if (wr_addr == ADDR_W'(SETUP_ADDR)) begin
                d.sh_sel  = wr_data[SEL_W-1:0];
                d.sh_fall = wr_data[SETUP_POL_BIT];
                d.sh_cnt  = wr_data[SETUP_CNT_LSB +: CNT_W];
            end
            if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
                d.en    = wr_data[CTRL_EN_BIT];
                clr_ovr = wr_data[CTRL_CLR_BIT];
            end
        end

        // active set tracks the shadow only while the channel is idle
        if (idle) begin
            d.ac_delay = q.sh_delay;
            d.ac_width = q.sh_width;
            d.ac_sel   = q.sh_sel;
            d.ac_fall  = q.sh_fall;
            d.ac_cnt   = q.sh_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign v_delay = idle ? q.sh_delay : q.ac_delay;
    assign v_width = idle ? q.sh_width : q.ac_width;
    assign v_sel   = idle ? q.sh_sel   : q.ac_sel;
    assign v_fall  = idle ? q.sh_fall  : q.ac_fall;
    assign v_cnt   = idle ? q.sh_cnt   : q.ac_cnt;
    assign enable  = q.en;

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(q.ac_delay) && $stable(q.ac_width) && $stable(q.ac_cnt))); // R8

    AST_TRIG_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(q.ac_sel) && $stable(q.ac_fall))); // R8

endmodule

// File: rtl/ptg_sequencer.sv
module ptg_sequencer
    import ptg_pkg::*;
#(
    parameter int MAX_ENTRIES = 10,
    parameter int TIME_W      = 16,
    parameter int CNT_W       = 4,
    parameter int TICK_DIV    = 50
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               enable,
    input  logic                               fire,
    input  logic                               clr_ovr,
    input  logic [MAX_ENTRIES-1:0][TIME_W-1:0] delays,
    input  logic [MAX_ENTRIES-1:0][TIME_W-1:0] widths,
    input  logic [CNT_W-1:0]                   cnt,
    output logic                               idle,
    output logic                               pulse,
    output logic                               overrun
);

    localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        phase_e            ph;
        logic [IDX_W-1:0]  idx;
        logic [TIME_W-1:0] rem;
        logic [PRE_W-1:0]  pre;
        logic              out;
        logic              ovr;
    } seq_st_t;

    seq_st_t          q, d;
    logic [CNT_W-1:0] eff_cnt;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] nxt_idx;
    logic             tick_end;
    logic             ph_done;
    logic             busy;

    always_comb begin
        if (cnt == '0)                          eff_cnt = CNT_W'(1);
        else if (cnt > CNT_W'(MAX_ENTRIES))     eff_cnt = CNT_W'(MAX_ENTRIES);
        else                                    eff_cnt = cnt;
        last_idx = IDX_W'(eff_cnt - 1'b1);
        nxt_idx  = q.idx + 1'b1;
        tick_end = (q.pre == PRE_W'(TICK_DIV - 1));
        ph_done  = (q.rem == '0) || ((q.rem == TIME_W'(1)) && tick_end);
        busy     = (q.ph != PH_IDLE);

        d     = q;
        d.out = 1'b0;

        if (clr_ovr)                 d.ovr = 1'b0;
        if (enable && fire && busy)  d.ovr = 1'b1;

        unique case (q.ph)
            PH_IDLE: begin
                if (enable && fire) begin
                    d.ph  = PH_GAP;
                    d.idx = '0;
                    d.rem = delays[0];
                    d.pre = '0;
                end
            end
            PH_GAP: begin
                if (ph_done) begin
                    d.ph  = PH_HIGH;
                    d.rem = widths[q.idx];
                    d.pre = '0;
                end else if (tick_end) begin
                    d.pre = '0;
                    d.rem = q.rem - 1'b1;
                end else begin
                    d.pre = q.pre + 1'b1;
                end
            end
            PH_HIGH: begin
                if (ph_done) begin
                    if (q.idx >= last_idx) begin
                        d.ph = PH_IDLE;
                    end else begin
                        d.ph  = PH_GAP;
                        d.idx = nxt_idx;
                        d.rem = delays[nxt_idx];
                        d.pre = '0;
                    end
                end else if (tick_end) begin
                    d.pre = '0;
                    d.rem = q.rem - 1'b1;
                end else begin
                    d.pre = q.pre + 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase

        if (!enable) begin
            d.ph  = PH_IDLE;
            d.idx = '0;
            d.rem = '0;
            d.pre = '0;
        end

        d.out = (d.ph == PH_HIGH) && (widths[d.idx] != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle    = (q.ph == PH_IDLE);
    assign pulse   = q.out;
    assign overrun = q.ovr;

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pulse); // R9

    AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && fire && !busy) |=> (q.ph == PH_GAP)); // R2

    AST_RETRIG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && fire && busy) |=> overrun); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_ovr) |=> overrun); // R7

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.idx <= last_idx)); // R5

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.pre <= PRE_W'(TICK_DIV - 1)); // R3

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
    import ptg_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int WORD_W      = 16,
    parameter int MAX_ENTRIES = 10,
    parameter int TIME_W      = 16,
    parameter int TICK_DIV    = 50,
    localparam int SEL_W      = (WORD_W > 1) ? $clog2(WORD_W) : 1,
    localparam int CNT_W      = $clog2(MAX_ENTRIES + 1),
    localparam int ADDR_W     = $clog2(MAX_ENTRIES + 2),
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DATA_W     = 2 * TIME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] trig_word,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pulse_out,
    output logic [NUM_CH-1:0] overrun
);

    logic [NUM_CH-1:0] ch_wr;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [MAX_ENTRIES-1:0][TIME_W-1:0] delays;
        logic [MAX_ENTRIES-1:0][TIME_W-1:0] widths;
        logic [SEL_W-1:0]                   sel;
        logic                               fall;
        logic [CNT_W-1:0]                   cnt;
        logic                               en;
        logic                               clr;
        logic                               idle;
        logic                               fire;

        assign ch_wr[c] = wr_en && (wr_ch == CH_W'(c));

        ptg_param_store #(
            .MAX_ENTRIES (MAX_ENTRIES),
            .TIME_W      (TIME_W),
            .SEL_W       (SEL_W),
            .CNT_W       (CNT_W),
            .ADDR_W      (ADDR_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ch_wr[c]),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .idle    (idle),
            .v_delay (delays),
            .v_width (widths),
            .v_sel   (sel),
            .v_fall  (fall),
            .v_cnt   (cnt),
            .enable  (en),
            .clr_ovr (clr)
        );

        ptg_edge_pick #(
            .WORD_W (WORD_W),
            .SEL_W  (SEL_W)
        ) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig_word (trig_word),
            .sel       (sel),
            .falling   (fall),
            .fire      (fire)
        );

        ptg_sequencer #(
            .MAX_ENTRIES (MAX_ENTRIES),
            .TIME_W      (TIME_W),
            .CNT_W       (CNT_W),
            .TICK_DIV    (TICK_DIV)
        ) u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (en),
            .fire    (fire),
            .clr_ovr (clr),
            .delays  (delays),
            .widths  (widths),
            .cnt     (cnt),
            .idle    (idle),
            .pulse   (pulse_out[c]),
            .overrun (overrun[c])
        );
    end

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr)); // R10

endmodule

// File: tb/sim_pulse_train_gen.sv
module sim_pulse_train_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int WW  = 16;
    localparam int NE  = 10;
    localparam int TW  = 16;
    localparam int DIV = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] trig = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_ch = '0;
    logic [3:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [NCH-1:0] pulse_out;
    logic [NCH-1:0] overrun;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_train_gen #(
        .NUM_CH(NCH), .WORD_W(WW), .MAX_ENTRIES(NE), .TIME_W(TW), .TICK_DIV(DIV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .trig_word(trig), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_addr(wr_addr), .wr_data(wr_data), .pulse_out(pulse_out), .overrun(overrun)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int m_d [NCH][NE];
    int m_w [NCH][NE];
    int m_cnt [NCH];

    // single-entry timing vectors: delay, width, falling, trigger bit
    localparam int NVEC = 6;
    localparam int VEC [NVEC][4] = '{
        '{3, 2, 0, 0},
        '{0, 1, 1, 4},
        '{1, 0, 0, 7},
        '{5, 4, 1, 15},
        '{2, 3, 0, 9},
        '{0, 0, 1, 1}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int plen(input int n);
        return (n == 0) ? 1 : n * DIV;
    endfunction

    function automatic int eff(input int c);
        return (c == 0) ? 1 : ((c > NE) ? NE : c);
    endfunction

    // expected output n clock edges after (and including) the trigger edge
    function automatic bit exp_at(input int ch, input int n);
        int t = 1;
        for (int i = 0; i < eff(m_cnt[ch]); i++) begin
            if (n < t + plen(m_d[ch][i])) return 1'b0;
            t += plen(m_d[ch][i]);
            if (n < t + plen(m_w[ch][i])) return (m_w[ch][i] != 0);
            t += plen(m_w[ch][i]);
        end
        return 1'b0;
    endfunction

    function automatic int seq_len(input int ch);
        int t = 0;
        for (int i = 0; i < eff(m_cnt[ch]); i++) t += plen(m_d[ch][i]) + plen(m_w[ch][i]);
        return t;
    endfunction

    task automatic hw_write(input int ch, input int a, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_addr = 4'(a); wr_data = 32'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_entry(input int ch, input int i, input int d, input int w);
        m_d[ch][i] = d; m_w[ch][i] = w;
        hw_write(ch, i, (d << 16) | w);
    endtask

    task automatic set_setup(input int ch, input int sel, input int fall, input int cnt);
        m_cnt[ch] = cnt;
        hw_write(ch, NE, sel | (fall << 8) | (cnt << 16));
    endtask

    task automatic set_ctrl(input int ch, input int en, input int clr);
        hw_write(ch, NE + 1, en | (clr << 1));
    endtask

    // drive an edge to level v on bit b and compare the channel output cycle by cycle
    task automatic watch(input int ch, input int b, input bit v, input bit arm,
                         input bit expect_run, input int rt, input string req);
        int bad = 0;
        int first = -1;
        int ga = 0;
        int ge = 0;
        int len;
        bit e;
        len = expect_run ? seq_len(ch) + 4 : 20;
        if (arm) begin
            @(negedge clk);
            trig[b] = !v;
        end
        @(negedge clk);
        trig[b] = v;
        for (int n = 1; n <= len; n++) begin
            @(posedge clk);
            #1;
            e = expect_run ? exp_at(ch, n) : 1'b0;
            if (pulse_out[ch] !== e) begin
                bad++;
                if (first < 0) begin
                    first = n; ga = int'(pulse_out[ch]); ge = int'(e);
                end
            end
            if (rt > 0 && n == rt)     trig[b] = !v;
            if (rt > 0 && n == rt + 2) trig[b] = v;
        end
        check(bad == 0, req, $sformatf("ch%0d output at cycle %0d", ch, first), ga, ge);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: got 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_cnt[c] = 0;
            for (int i = 0; i < NE; i++) begin m_d[c][i] = 0; m_w[c][i] = 0; end
        end

        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check(pulse_out == '0, "R1", "pulse_out in reset", int'(pulse_out), 0);
        check(overrun == '0, "R1", "overrun in reset", int'(overrun), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 channel stays quiet while disabled after reset
        set_entry(0, 0, 1, 1);
        set_setup(0, 0, 0, 1);
        watch(0, 0, 1'b1, 1'b1, 1'b0, 0, "R9");
        set_ctrl(0, 1, 0);

        // table of single-pulse timings: R3 latency/width, R2 polarity, R6 zero width
        for (int k = 0; k < NVEC; k++) begin
            set_entry(0, 0, VEC[k][0], VEC[k][1]);
            set_setup(0, VEC[k][3], VEC[k][2], 1);
            watch(0, VEC[k][3], !VEC[k][2], 1'b1, 1'b1, 0,
                  (VEC[k][1] == 0) ? "R6" : (VEC[k][2] != 0 ? "R2" : "R3"));
        end

        // R2 other bit and opposite edge start nothing
        set_entry(0, 0, 1, 2);
        set_setup(0, 2, 0, 1);
        watch(0, 3, 1'b1, 1'b1, 1'b0, 0, "R2");
        watch(0, 2, 1'b1, 1'b1, 1'b1, 0, "R2");
        watch(0, 2, 1'b0, 1'b0, 1'b0, 0, "R2");
        check(overrun[0] == 1'b0, "R2", "overrun after ignored edges", int'(overrun[0]), 0);

        // R4 ordered multi-pulse list, fourth entry beyond count unused
        set_ctrl(1, 1, 0);
        set_entry(1, 0, 2, 1);
        set_entry(1, 1, 1, 3);
        set_entry(1, 2, 0, 2);
        set_entry(1, 3, 4, 1);
        set_setup(1, 5, 0, 3);
        watch(1, 5, 1'b1, 1'b1, 1'b1, 0, "R4");

        // R5 count clamps
        set_setup(1, 5, 0, 0);
        watch(1, 5, 1'b1, 1'b1, 1'b1, 0, "R5");
        set_ctrl(2, 1, 0);
        for (int i = 0; i < NE; i++) set_entry(2, i, 1, (i % 2) + 1);
        set_setup(2, 6, 1, 15);
        watch(2, 6, 1'b0, 1'b1, 1'b1, 0, "R5");

        // R7 retrigger mid-run
        set_entry(0, 0, 4, 4);
        set_setup(0, 0, 0, 1);
        check(overrun[0] == 1'b0, "R7", "overrun before retrigger", int'(overrun[0]), 0);
        watch(0, 0, 1'b1, 1'b1, 1'b1, 3, "R7");
        check(overrun[0] == 1'b1, "R7", "overrun after retrigger", int'(overrun[0]), 1);
        repeat (5) @(posedge clk);
        #1;
        check(overrun[0] == 1'b1, "R7", "overrun held", int'(overrun[0]), 1);
        set_ctrl(0, 1, 1);
        check(overrun[0] == 1'b0, "R7", "overrun after clear", int'(overrun[0]), 0);

        // R8 write during a run applies from the next run
        set_entry(0, 0, 3, 5);
        fork
            watch(0, 0, 1'b1, 1'b1, 1'b1, 0, "R8");
            begin repeat (5) @(negedge clk); hw_write(0, 0, (1 << 16) | 1); end
        join
        m_d[0][0] = 1; m_w[0][0] = 1;
        watch(0, 0, 1'b1, 1'b1, 1'b1, 0, "R8");

        // R8 write in the very cycle of the trigger
        fork
            watch(0, 0, 1'b1, 1'b1, 1'b1, 0, "R8");
            begin @(negedge clk); hw_write(0, 0, (2 << 16) | 2); end
        join
        m_d[0][0] = 2; m_w[0][0] = 2;
        watch(0, 0, 1'b1, 1'b1, 1'b1, 0, "R8");

        // R9 disable in the middle of a pulse
        set_entry(0, 0, 0, 20);
        @(negedge clk); trig[0] = 1'b0;
        @(negedge clk); trig[0] = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        check(pulse_out[0] == 1'b1, "R9", "pulse before disable", int'(pulse_out[0]), 1);
        set_ctrl(0, 0, 0);
        @(posedge clk);
        #1;
        check(pulse_out[0] == 1'b0, "R9", "pulse after disable", int'(pulse_out[0]), 0);
        set_ctrl(0, 1, 0);
        check(overrun[0] == 1'b0, "R9", "overrun after abandon", int'(overrun[0]), 0);
        watch(0, 0, 1'b1, 1'b1, 1'b1, 0, "R9");

        // R10 two channels triggered together
        set_entry(1, 0, 1, 2);
        set_setup(1, 10, 0, 1);
        set_ctrl(3, 1, 0);
        set_entry(3, 0, 2, 1);
        set_setup(3, 11, 1, 1);
        fork
            watch(1, 10, 1'b1, 1'b1, 1'b1, 0, "R10");
            watch(3, 11, 1'b0, 1'b1, 1'b1, 0, "R10");
        join
        check(overrun == '0, "R10", "overrun after joint run", int'(overrun), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule